// File: doc/BRIEF.md
# Mask-Driven Vector Compress and Expand Unit

The unit rearranges the elements of a 512-bit vector under control of a per-element mask. It has two operations. Expand takes the low elements of the source in order and places them into the destination positions whose mask bit is set. Compress works the other way: it packs the source elements whose mask bit is set into the lowest result positions.

Elements are 32 or 64 bits wide. The active vector length is 128, 256 or 512 bits. Positions that the operation does not fill are either zeroed or merged from an old destination value, as selected by a zeroing flag. Alongside the data, the unit gives a per-element write-enable mask for the consumer: a register write port or a byte-masked store.

All placement logic is combinational and is built on running prefix counts of the mask. The result and the write mask are registered, so a request presented in one cycle appears at the outputs one clock edge later.

Top module: `vcx_engine`

## Requirements
- R1: In expand (op_i=0), active destination element n with mask bit n set takes source element k, where k is the number of set mask bits below n. Source elements are therefore consumed in order, starting from element 0.
- R2: In expand, an active destination element whose mask bit is clear is 0 when zmask_i=1 and is the same element of old_i when zmask_i=0.
- R3: In compress (op_i=1), each active source element n whose mask bit is set is written to result element k, where k is the number of set mask bits below n.
- R4: In compress, active result elements at or above the selected count K are 0 when zmask_i=1 and come from old_i when zmask_i=0.
- R5: In compress, wmask_o equals (1<<K)-1, where K is the number of selected active elements. This is a contiguous run of ones starting at bit 0.
- R6: In expand, wmask_o has bit i set exactly for every active element i.
- R7: The number of active elements is 4·L for 32-bit elements (esize64_i=0) and 2·L for 64-bit elements (esize64_i=1). L is the number of 128-bit lanes: L=1 for vl_i=0, L=2 for vl_i=1, and L=4 for vl_i=2 or 3. Mask bits at or above the active element count have no effect. Element i occupies bits [i·W +: W] of every vector, where W is the element width.
- R8: Every result bit at or above the active vector length is 0.
- R9: With esize64_i=1, mask bit i governs the whole 64-bit element i.
- R10: While rst_n is low, res_o and wmask_o are 0. Otherwise they show the result of the inputs sampled at the previous rising clock edge.
- R11: A mask with no active bits set gives wmask_o=0 for compress. For expand it gives an all-zero result when zmask_i=1 and the old value within the active length when zmask_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 1 | 0 = expand, 1 = compress |
| esize64_i | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| vl_i | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| zmask_i | input | 1 | 1 = zero unfilled positions, 0 = merge from old_i |
| mask_i | input | 16 | Per-element select mask, bit i for element i |
| src_i | input | 512 | Source vector |
| old_i | input | 512 | Old destination vector used for merging |
| res_o | output | 512 | Registered result vector |
| wmask_o | output | 16 | Registered per-element write enable |

## Verification
Several rules apply to the same element in the same cycle. An element can be past the compress count K, subject to merge or zeroing, and also beyond the active length, so the K boundary, the zeroing choice and the upper clearing all meet there. In the same way, a mask bit set above the active element count must be ignored even while the write-mask run is being formed. The bench provokes these overlaps by sweeping every combination of operation, element size, length and zeroing flag. Each combination uses full 16-bit masks: corner patterns and pseudo-random ones, so that bits above the active count are often set. Every result and write mask is judged against an element-level reference loop in the bench.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
    parameter int VCX_VEC_W  = 512;
    parameter int VCX_SLOT_W = 32;
    parameter int VCX_NSLOT  = VCX_VEC_W / VCX_SLOT_W;
    parameter int VCX_MASK_W = VCX_NSLOT;
    parameter int VCX_CNT_W  = $clog2(VCX_NSLOT + 1);

    typedef enum logic {
        VCX_EXPAND   = 1'b0,
        VCX_COMPRESS = 1'b1
    } vcx_op_e;

    typedef struct packed {
        logic [VCX_VEC_W-1:0]  res;
        logic [VCX_MASK_W-1:0] wmask;
    } vcx_state_t;
endpackage

// File: rtl/vcx_slot_mask.sv
// Maps the element mask onto 32-bit slots and derives the active ranges.
module vcx_slot_mask
    import vcx_pkg::*;
#(
    parameter int VEC_W  = VCX_VEC_W,
    parameter int SLOT_W = VCX_SLOT_W,
    parameter int NSLOT  = VCX_NSLOT,
    parameter int MASK_W = VCX_MASK_W,
    parameter int CNT_W  = VCX_CNT_W
) (
    input  logic              esize64_i,
    input  logic [1:0]        vl_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [NSLOT-1:0]  dmask_o,
    output logic [NSLOT-1:0]  act_o,
    output logic [MASK_W-1:0] emask_o
);
    localparam int LANE_SLOTS = 128 / SLOT_W;
    localparam int LANES      = VEC_W / 128;

    logic [CNT_W-1:0] nslot_act;
    logic [CNT_W-1:0] nelem_act;

    always_comb begin
        case (vl_i)
            2'd0:    nslot_act = CNT_W'(LANE_SLOTS);
            2'd1:    nslot_act = CNT_W'(2 * LANE_SLOTS);
            default: nslot_act = CNT_W'(LANES * LANE_SLOTS);
        endcase
        nelem_act = esize64_i ? (nslot_act >> 1) : nslot_act;
        for (int n = 0; n < NSLOT; n++) begin
            act_o[n]   = CNT_W'(n) < nslot_act;
            dmask_o[n] = act_o[n] & (esize64_i ? mask_i[n / 2] : mask_i[n]);
        end
        for (int i = 0; i < MASK_W; i++) begin
            emask_o[i] = CNT_W'(i) < nelem_act;
        end
    end
endmodule

// File: rtl/vcx_prefix.sv
// Running count of set slot-mask bits strictly below each slot.
module vcx_prefix
    import vcx_pkg::*;
#(
    parameter int NSLOT = VCX_NSLOT,
    parameter int CNT_W = VCX_CNT_W
) (
    input  logic [NSLOT-1:0]            dmask_i,
    output logic [NSLOT-1:0][CNT_W-1:0] pre_o,
    output logic [CNT_W-1:0]            total_o
);
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int n = 0; n < NSLOT; n++) begin
            pre_o[n] = run;
            run      = run + CNT_W'(dmask_i[n]);
        end
        total_o = run;
    end
endmodule

// File: rtl/vcx_expand.sv
module vcx_expand
    import vcx_pkg::*;
#(
    parameter int SLOT_W = VCX_SLOT_W,
    parameter int NSLOT  = VCX_NSLOT,
    parameter int CNT_W  = VCX_CNT_W
) (
    input  logic [NSLOT*SLOT_W-1:0]     src_i,
    input  logic [NSLOT*SLOT_W-1:0]     old_i,
    input  logic [NSLOT-1:0]            dmask_i,
    input  logic [NSLOT-1:0]            act_i,
    input  logic                        zmask_i,
    input  logic [NSLOT-1:0][CNT_W-1:0] pre_i,
    output logic [NSLOT*SLOT_W-1:0]     res_o
);
    localparam int IDX_W = $clog2(NSLOT);

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        logic [IDX_W-1:0] idx;
        assign idx = pre_i[n][IDX_W-1:0];
        always_comb begin
            if (!act_i[n])
                res_o[n*SLOT_W +: SLOT_W] = '0;
            else if (dmask_i[n])
                res_o[n*SLOT_W +: SLOT_W] = src_i[idx*SLOT_W +: SLOT_W];
            else if (zmask_i)
                res_o[n*SLOT_W +: SLOT_W] = '0;
            else
                res_o[n*SLOT_W +: SLOT_W] = old_i[n*SLOT_W +: SLOT_W];
        end
    end
endmodule

// File: rtl/vcx_compress.sv
module vcx_compress
    import vcx_pkg::*;
#(
    parameter int SLOT_W = VCX_SLOT_W,
    parameter int NSLOT  = VCX_NSLOT,
    parameter int CNT_W  = VCX_CNT_W
) (
    input  logic [NSLOT*SLOT_W-1:0]     src_i,
    input  logic [NSLOT*SLOT_W-1:0]     old_i,
    input  logic [NSLOT-1:0]            dmask_i,
    input  logic [NSLOT-1:0]            act_i,
    input  logic                        zmask_i,
    input  logic [NSLOT-1:0][CNT_W-1:0] pre_i,
    input  logic [CNT_W-1:0]            total_i,
    output logic [NSLOT*SLOT_W-1:0]     res_o
);
    for (genvar j = 0; j < NSLOT; j++) begin : g_out
        logic [SLOT_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int n = j; n < NSLOT; n++) begin
                if (dmask_i[n] && pre_i[n] == CNT_W'(j))
                    pick = pick | src_i[n*SLOT_W +: SLOT_W];
            end
            if (!act_i[j])
                res_o[j*SLOT_W +: SLOT_W] = '0;
            else if (CNT_W'(j) < total_i)
                res_o[j*SLOT_W +: SLOT_W] = pick;
            else if (zmask_i)
                res_o[j*SLOT_W +: SLOT_W] = '0;
            else
                res_o[j*SLOT_W +: SLOT_W] = old_i[j*SLOT_W +: SLOT_W];
        end
    end
endmodule

// File: rtl/vcx_engine.sv
module vcx_engine
    import vcx_pkg::*;
#(
    parameter int VEC_W  = VCX_VEC_W,
    parameter int SLOT_W = VCX_SLOT_W,
    parameter int NSLOT  = VCX_NSLOT,
    parameter int MASK_W = VCX_MASK_W,
    parameter int CNT_W  = VCX_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_i,
    input  logic              esize64_i,
    input  logic [1:0]        vl_i,
    input  logic              zmask_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [VEC_W-1:0]  src_i,
    input  logic [VEC_W-1:0]  old_i,
    output logic [VEC_W-1:0]  res_o,
    output logic [MASK_W-1:0] wmask_o
);
    logic [NSLOT-1:0]            dmask;
    logic [NSLOT-1:0]            act;
    logic [MASK_W-1:0]           emask;
    logic [NSLOT-1:0][CNT_W-1:0] pre;
    logic [CNT_W-1:0]            total;
    logic [VEC_W-1:0]            exp_res;
    logic [VEC_W-1:0]            cmp_res;
    logic [CNT_W-1:0]            sel_elems;
    vcx_state_t                  state_d, state_q;

    vcx_slot_mask #(.VEC_W(VEC_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT), .MASK_W(MASK_W), .CNT_W(CNT_W)) u_slot_mask (
        .esize64_i(esize64_i), .vl_i(vl_i), .mask_i(mask_i),
        .dmask_o(dmask), .act_o(act), .emask_o(emask)
    );

    vcx_prefix #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_prefix (
        .dmask_i(dmask), .pre_o(pre), .total_o(total)
    );

    vcx_expand #(.SLOT_W(SLOT_W), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_expand (
        .src_i(src_i), .old_i(old_i), .dmask_i(dmask), .act_i(act),
        .zmask_i(zmask_i), .pre_i(pre), .res_o(exp_res)
    );

    vcx_compress #(.SLOT_W(SLOT_W), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_compress (
        .src_i(src_i), .old_i(old_i), .dmask_i(dmask), .act_i(act),
        .zmask_i(zmask_i), .pre_i(pre), .total_i(total), .res_o(cmp_res)
    );

    always_comb begin
        sel_elems = esize64_i ? (total >> 1) : total;
        state_d.res = (vcx_op_e'(op_i) == VCX_COMPRESS) ? cmp_res : exp_res;
        for (int i = 0; i < MASK_W; i++) begin
            state_d.wmask[i] = (vcx_op_e'(op_i) == VCX_COMPRESS) ? (CNT_W'(i) < sel_elems) : emask[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_o   = state_q.res;
    assign wmask_o = state_q.wmask;

    assert_reset_clear_R10: assert property (@(posedge clk) !rst_n |-> (res_o == '0 && wmask_o == '0));

    assert_cmp_wmask_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i |=> ((wmask_o & (wmask_o + MASK_W'(1))) == '0));

    assert_cmp_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i && !esize64_i && vl_i == 2'd2) |=> ($countones(wmask_o) == $countones($past(mask_i))));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_i == 2'd0) |=> (res_o[VEC_W-1:128] == '0));

    assert_wide_wmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        esize64_i |=> (wmask_o[MASK_W-1:MASK_W/2] == '0));

    assert_empty_expand_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_i && zmask_i && mask_i == '0) |=> (res_o == '0));
endmodule

// File: tb/vcx_engine_bench.sv
module vcx_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_i = 1'b0, esize64_i = 1'b0, zmask_i = 1'b0;
    logic [1:0]   vl_i = 2'd0;
    logic [15:0]  mask_i = '0;
    logic [511:0] src_i = '0, old_i = '0;
    logic [511:0] res_o;
    logic [15:0]  wmask_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vcx_engine u_vcx_engine (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .esize64_i(esize64_i), .vl_i(vl_i),
        .zmask_i(zmask_i), .mask_i(mask_i), .src_i(src_i), .old_i(old_i),
        .res_o(res_o), .wmask_o(wmask_o)
    );

    function automatic logic [63:0] get_e(logic [511:0] v, int e, bit w64);
        return w64 ? v[e*64 +: 64] : {32'b0, v[e*32 +: 32]};
    endfunction

    function automatic logic [511:0] put_e(logic [511:0] v, int e, bit w64, logic [63:0] x);
        logic [511:0] r;
        r = v;
        if (w64) r[e*64 +: 64] = x;
        else     r[e*32 +: 32] = x[31:0];
        return r;
    endfunction

    task automatic check_vec(string tag, logic [511:0] got, logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_msk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_one(bit op, bit w64, logic [1:0] vl, bit z, logic [15:0] m);
        logic [511:0] exp;
        logic [15:0]  expw;
        int lanes, ne, k;
        bit any;
        lanes = (vl == 2'd0) ? 1 : (vl == 2'd1) ? 2 : 4;
        ne    = (w64 ? 2 : 4) * lanes;
        @(negedge clk);
        op_i = op; esize64_i = w64; vl_i = vl; zmask_i = z; mask_i = m;
        for (int d = 0; d < 16; d++) begin
            src_i[d*32 +: 32] = $urandom;
            old_i[d*32 +: 32] = $urandom;
        end
        exp = '0; expw = '0; k = 0; any = 1'b0;
        for (int n = 0; n < ne; n++) any |= m[n];
        if (!op) begin
            for (int n = 0; n < ne; n++) begin
                expw[n] = 1'b1;
                if (m[n]) begin
                    exp = put_e(exp, n, w64, get_e(src_i, k, w64));
                    k++;
                end else begin
                    exp = put_e(exp, n, w64, z ? 64'b0 : get_e(old_i, n, w64));
                end
            end
        end else begin
            for (int n = 0; n < ne; n++) begin
                if (m[n]) begin
                    exp = put_e(exp, k, w64, get_e(src_i, n, w64));
                    k++;
                end
            end
            for (int j = k; j < ne; j++) exp = put_e(exp, j, w64, z ? 64'b0 : get_e(old_i, j, w64));
            expw = 16'((32'd1 << k) - 1);
        end
        @(negedge clk);
        if (!any) begin
            check_vec("R11 empty mask result", res_o, exp);
            check_msk("R11 empty mask wmask", wmask_o, expw);
        end else if (!op) begin
            check_vec(w64 ? "R1 R2 R8 R9 expand64" : "R1 R2 R8 expand32", res_o, exp);
            check_msk("R6 R7 expand wmask", wmask_o, expw);
        end else begin
            check_vec(w64 ? "R3 R4 R8 R9 compress64" : "R3 R4 R8 compress32", res_o, exp);
            check_msk("R5 R7 compress wmask", wmask_o, expw);
        end
    endtask

    initial begin
        logic [15:0] corner [6];
        corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h0001;
        corner[3] = 16'h8000; corner[4] = 16'hAAAA; corner[5] = 16'h5555;
        repeat (3) @(negedge clk);
        check_vec("R10 reset result", res_o, '0);
        check_msk("R10 reset wmask", wmask_o, '0);
        rst_n = 1'b1;
        for (int op = 0; op < 2; op++)
            for (int w = 0; w < 2; w++)
                for (int vl = 0; vl < 4; vl++)
                    for (int z = 0; z < 2; z++)
                        for (int t = 0; t < 120; t++)
                            run_one(op[0], w[0], vl[1:0], z[0], (t < 6) ? corner[t] : 16'($urandom));
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule